// File: doc/BRIEF.md
# Streaming CRC Generator with Checksum Append

This block computes a cyclic redundancy checksum over a framed word stream and sends the checksum out on the same bus after the message. Each input word is W bits wide and comes with valid, start and end strobes. Every valid word is echoed on the output one cycle later. After the word that carries the end strobe, the block inserts CRC_LEN/W checksum words. The output end strobe moves from the last message word to the last checksum word.

The configuration is fixed at elaboration and cannot change at run time:
- the generator polynomial, written with the x^CRC_LEN coefficient as its top bit;
- the starting register value, given either as a full vector or as one bit copied to every position;
- the update form: plain shift-register, or augmented-message with a zero flush at the end;
- per-byte reversal of the input bits;
- full reversal of the checksum;
- a final XOR mask.

The block has no backpressure. The source must leave at least CRC_LEN/W idle cycles after each end word so that the appended words fit.

Top module: `crcapp_gen`

## Requirements
- R1: Each word sampled with in_valid high appears on out_data one cycle later. On that cycle out_valid is high, out_start equals the sampled in_start, and out_end is low.
- R2: After the end word has been echoed, exactly CRC_LEN/W checksum words follow on consecutive cycles. The most significant W bits come first. out_end is high only on the last of them, and out_start is low on all of them.
- R3: A cycle with in_valid low is ignored, whatever in_data, in_start and in_end carry. It produces no output word and does not change the checksum. On any cycle that emits nothing, out_valid, out_start and out_end are low and out_data is zero.
- R4: A valid word with in_start high loads the starting value before it is folded in. A frame of one word, with start and end on the same cycle, is handled.
- R5: In the plain form, data bits are taken from bit W-1 down to bit 0. For each bit, the feedback is the register MSB XOR the data bit. The register shifts left with a 0 entering. When the feedback is 1, the low CRC_LEN bits of the polynomial are XORed in. The default polynomial is x^16+x^12+x^5+1 (17'h11021), with starting value 0, no reflection and mask 0.
- R6: In the augmented form, the data bit enters at the register LSB and the feedback is the old MSB. After the last word, CRC_LEN zero bits are processed the same way before the checksum is formed.
- R7: The starting value is the vector parameter. When the replicate option is set, it is instead one parameter bit copied to all CRC_LEN positions.
- R8: With input reflection, the bit order inside each 8-bit lane of the word is reversed before processing, so bit 0 of each byte goes first. W must be a multiple of 8.
- R9: With checksum reflection, the CRC_LEN-bit result is reversed end to end (bit 0 becomes the MSB). This happens before the mask.
- R10: The final mask is XORed onto the checksum as the last step before it is appended.
- R11: While rst_n is low, out_valid, out_start and out_end are low and out_data is zero.
- R12: A new frame may start on the cycle right after the last of the CRC_LEN/W required idle cycles. Its words and checksum are correct. A valid word while checksum words are still pending is a protocol violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | W | Message word |
| in_valid | input | 1 | Input word qualifier |
| in_start | input | 1 | First word of a frame |
| in_end | input | 1 | Last word of a frame |
| out_data | output | W | Echoed message word or checksum word |
| out_valid | output | 1 | Output word qualifier |
| out_start | output | 1 | First output word of a frame |
| out_end | output | 1 | Last checksum word of a frame |

## Verification
The bench goes after three groups of corner cases.

**Frame boundaries.** It sends one-word frames, where start and end coincide, and back-to-back frames with exactly the minimum gap. A design that failed to reload the starting value would carry the previous frame's remainder into the checksum. A design that mistimed the append would drop or duplicate a checksum word.

**Ignored cycles.** Invalid cycles carry random data and stray start and end strobes. A design that let those update the register, or echoed them, would show a wrong checksum or an extra output word.

**Configuration variants.** A second instance turns on the byte lane reversal, the augmented form with its flush, the replicated starting value, the checksum reversal and the mask. That instance uses an 8-bit bus, so the two checksum words also check the word order and that the end strobe lands only on the second word.

// File: rtl/crcapp_pkg.sv
package crcapp_pkg;

   typedef struct packed {
      logic valid;
      logic start;
      logic stop;
   } beat_flags_t;

   function automatic int words_per_crc(input int crc_len, input int width);
      return crc_len / width;
   endfunction

endpackage

// File: rtl/crcapp_step.sv
// Folds one W-bit word into the CRC register, all bits in one cycle.
module crcapp_step #(
   parameter int         W          = 16,
   parameter int         L          = 16,
   parameter logic [L:0] POLY       = 17'h11021,
   parameter bit         DIRECT     = 1'b0,
   parameter bit         REFLECT_IN = 1'b0
) (
   input  logic [L-1:0] crc_i,
   input  logic [W-1:0] word_i,
   output logic [L-1:0] crc_o
);

   localparam logic [L-1:0] TAPS = POLY[L-1:0];

   logic [W-1:0] word_ord;

   generate
      if (REFLECT_IN) begin : g_lane_rev
         for (genvar b = 0; b < W / 8; b++) begin : g_lane
            for (genvar j = 0; j < 8; j++) begin : g_bit
               assign word_ord[b*8+j] = word_i[b*8+7-j];
            end
         end
      end else begin : g_lane_keep
         assign word_ord = word_i;
      end

      if (DIRECT) begin : g_augmented
         logic [L-1:0] acc;
         always_comb begin
            acc = crc_i;
            for (int k = W - 1; k >= 0; k--) begin
               acc = {acc[L-2:0], word_ord[k]} ^ (acc[L-1] ? TAPS : '0);
            end
            crc_o = acc;
         end
      end else begin : g_plain
         logic [L-1:0] acc;
         always_comb begin
            acc = crc_i;
            for (int k = W - 1; k >= 0; k--) begin
               acc = {acc[L-2:0], 1'b0} ^ ((acc[L-1] ^ word_ord[k]) ? TAPS : '0);
            end
            crc_o = acc;
         end
      end
   endgenerate

endmodule

// File: rtl/crcapp_finish.sv
// Turns the register contents into the checksum: optional zero flush,
// optional full reversal, then the mask.
module crcapp_finish #(
   parameter int         L           = 16,
   parameter logic [L:0] POLY        = 17'h11021,
   parameter bit         DIRECT      = 1'b0,
   parameter bit         REFLECT_OUT = 1'b0,
   parameter logic [L-1:0] XOR_OUT   = '0
) (
   input  logic [L-1:0] crc_i,
   output logic [L-1:0] chk_o
);

   localparam logic [L-1:0] TAPS = POLY[L-1:0];

   logic [L-1:0] flushed;
   logic [L-1:0] ordered;

   generate
      if (DIRECT) begin : g_flush
         logic [L-1:0] acc;
         always_comb begin
            acc = crc_i;
            for (int k = 0; k < L; k++) begin
               acc = {acc[L-2:0], 1'b0} ^ (acc[L-1] ? TAPS : '0);
            end
            flushed = acc;
         end
      end else begin : g_no_flush
         assign flushed = crc_i;
      end

      if (REFLECT_OUT) begin : g_rev
         for (genvar i = 0; i < L; i++) begin : g_bit
            assign ordered[i] = flushed[L-1-i];
         end
      end else begin : g_keep
         assign ordered = flushed;
      end
   endgenerate

   assign chk_o = ordered ^ XOR_OUT;

endmodule

// File: rtl/crcapp_emit.sv
// Output register: echoes message words, then shifts out the checksum.
module crcapp_emit
   import crcapp_pkg::*;
#(
   parameter int W = 16,
   parameter int L = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_start,
   input  logic         in_end,
   input  logic [W-1:0] in_data,
   input  logic [L-1:0] chk_i,
   output logic [W-1:0] out_data,
   output logic         out_valid,
   output logic         out_start,
   output logic         out_end
);

   localparam int NW = words_per_crc(L, W);
   localparam int CW = $clog2(NW + 1);

   logic [L-1:0]  tail_sr;
   logic [CW-1:0] tail_cnt;
   logic [W-1:0]  data_q;
   beat_flags_t   flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail_sr  <= '0;
         tail_cnt <= '0;
         data_q   <= '0;
         flags_q  <= '0;
      end else if (in_valid) begin
         data_q        <= in_data;
         flags_q.valid <= 1'b1;
         flags_q.start <= in_start;
         flags_q.stop  <= 1'b0;
         if (in_end) begin
            tail_sr  <= chk_i;
            tail_cnt <= CW'(NW);
         end
      end else if (tail_cnt != '0) begin
         data_q        <= tail_sr[L-1 -: W];
         flags_q.valid <= 1'b1;
         flags_q.start <= 1'b0;
         flags_q.stop  <= (tail_cnt == CW'(1));
         tail_sr       <= tail_sr << W;
         tail_cnt      <= tail_cnt - CW'(1);
      end else begin
         data_q  <= '0;
         flags_q <= '0;
      end
   end

   assign out_data  = data_q;
   assign out_valid = flags_q.valid;
   assign out_start = flags_q.start;
   assign out_end   = flags_q.stop;

endmodule

// File: rtl/crcapp_gen.sv
module crcapp_gen #(
   parameter int               W              = 16,
   parameter int               CRC_LEN        = 16,
   parameter logic [CRC_LEN:0] POLY           = 17'h11021,
   parameter logic [CRC_LEN-1:0] INIT_VALUE   = '0,
   parameter bit               INIT_REPLICATE = 1'b0,
   parameter bit               INIT_BIT       = 1'b0,
   parameter bit               DIRECT         = 1'b0,
   parameter bit               REFLECT_IN     = 1'b0,
   parameter bit               REFLECT_OUT    = 1'b0,
   parameter logic [CRC_LEN-1:0] XOR_OUT      = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   input  logic         in_start,
   input  logic         in_end,
   output logic [W-1:0] out_data,
   output logic         out_valid,
   output logic         out_start,
   output logic         out_end
);

   localparam logic [CRC_LEN-1:0] INIT_EFF =
      INIT_REPLICATE ? {CRC_LEN{INIT_BIT}} : INIT_VALUE;

   generate
      if (CRC_LEN < 2) begin : g_err_len
         $error("CRC_LEN must be at least 2");
      end
      if (W > CRC_LEN || (CRC_LEN % W) != 0) begin : g_err_ratio
         $error("W must divide CRC_LEN and not exceed it");
      end
      if (POLY[CRC_LEN] != 1'b1) begin : g_err_poly
         $error("POLY top coefficient must be 1");
      end
      if (REFLECT_IN && (W % 8) != 0) begin : g_err_lane
         $error("input reflection needs W to be a multiple of 8");
      end
   endgenerate

   logic [CRC_LEN-1:0] crc_q;
   logic [CRC_LEN-1:0] crc_base;
   logic [CRC_LEN-1:0] crc_next;
   logic [CRC_LEN-1:0] chk;

   assign crc_base = in_start ? INIT_EFF : crc_q;

   crcapp_step #(
      .W(W), .L(CRC_LEN), .POLY(POLY), .DIRECT(DIRECT), .REFLECT_IN(REFLECT_IN)
   ) u_step (
      .crc_i(crc_base), .word_i(in_data), .crc_o(crc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= INIT_EFF;
      end else if (in_valid) begin
         crc_q <= crc_next;
      end
   end

   crcapp_finish #(
      .L(CRC_LEN), .POLY(POLY), .DIRECT(DIRECT),
      .REFLECT_OUT(REFLECT_OUT), .XOR_OUT(XOR_OUT)
   ) u_finish (
      .crc_i(crc_next), .chk_o(chk)
   );

   crcapp_emit #(
      .W(W), .L(CRC_LEN)
   ) u_emit (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_start(in_start), .in_end(in_end),
      .in_data(in_data), .chk_i(chk),
      .out_data(out_data), .out_valid(out_valid),
      .out_start(out_start), .out_end(out_end)
   );

endmodule

// File: rtl/crcapp_gen_chk.sv
module crcapp_gen_chk #(
   parameter int W = 16,
   parameter int L = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] in_data,
   input logic         in_valid,
   input logic         in_start,
   input logic         in_end,
   input logic [W-1:0] out_data,
   input logic         out_valid,
   input logic         out_start,
   input logic         out_end
);

   localparam int NW = L / W;

   int pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 0;
      end else if (in_valid && in_end) begin
         pend <= NW;
      end else if (!in_valid && pend != 0) begin
         pend <= pend - 1;
      end
   end

   AST_ECHO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid && out_data == $past(in_data)
                   && out_start == $past(in_start) && !out_end); // R1

   AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> out_valid); // R1

   AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && pend == 1) |=> out_valid && out_end && !out_start); // R2

   AST_END_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid || pend != 1) |=> !out_end); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && pend == 0) |=> !out_valid && out_data == '0); // R3

   AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> pend == 0); // R12

endmodule

bind crcapp_gen crcapp_gen_chk #(.W(W), .L(CRC_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
   .in_start(in_start), .in_end(in_end), .out_data(out_data),
   .out_valid(out_valid), .out_start(out_start), .out_end(out_end)
);

// File: tb/sim_crcapp_gen.sv
module sim_crcapp_gen;

   localparam logic [16:0] P0 = 17'h11021;
   localparam logic [16:0] P1 = 17'h18005;
   localparam logic [15:0] X1 = 16'hA5C3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [15:0] i0_d = '0;
   logic        i0_v = 1'b0, i0_s = 1'b0, i0_e = 1'b0;
   logic [15:0] o0_d;
   logic        o0_v, o0_s, o0_e;
   logic [7:0]  i1_d = '0;
   logic        i1_v = 1'b0, i1_s = 1'b0, i1_e = 1'b0;
   logic [7:0]  o1_d;
   logic        o1_v, o1_s, o1_e;

   crcapp_gen u0 (
      .clk(clk), .rst_n(rst_n), .in_data(i0_d), .in_valid(i0_v),
      .in_start(i0_s), .in_end(i0_e), .out_data(o0_d), .out_valid(o0_v),
      .out_start(o0_s), .out_end(o0_e)
   );

   crcapp_gen #(
      .W(8), .CRC_LEN(16), .POLY(P1), .INIT_VALUE(16'h0000),
      .INIT_REPLICATE(1'b1), .INIT_BIT(1'b1), .DIRECT(1'b1),
      .REFLECT_IN(1'b1), .REFLECT_OUT(1'b1), .XOR_OUT(X1)
   ) u1 (
      .clk(clk), .rst_n(rst_n), .in_data(i1_d), .in_valid(i1_v),
      .in_start(i1_s), .in_end(i1_e), .out_data(o1_d), .out_valid(o1_v),
      .out_start(o1_s), .out_end(o1_e)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit run    = 1'b0;

   int unsigned q_data[2][$];
   bit          q_s[2][$];
   bit          q_e[2][$];
   string       q_tag[2][$];

   task automatic check(input string tag, input bit ok, input string what,
                        input int unsigned act, input int unsigned exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Bit-serial reference of the checksum definition.
   function automatic logic [15:0] ref_crc(input int unsigned words[$], input int w,
         input logic [16:0] poly, input logic [15:0] init, input bit direct,
         input bit refin, input bit refout, input logic [15:0] xorv);
      logic [15:0] c = init;
      logic [15:0] r;
      foreach (words[k]) begin
         for (int b = w - 1; b >= 0; b--) begin
            int idx = refin ? ((b / 8) * 8 + 7 - (b % 8)) : b;
            bit d = words[k][idx];
            bit fb;
            if (direct) begin
               fb = c[15];
               c = {c[14:0], d};
            end else begin
               fb = c[15] ^ d;
               c = {c[14:0], 1'b0};
            end
            if (fb) c = c ^ poly[15:0];
         end
      end
      if (direct) begin
         for (int z = 0; z < 16; z++) begin
            bit fb = c[15];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ poly[15:0];
         end
      end
      if (refout) begin
         for (int i = 0; i < 16; i++) r[i] = c[15-i];
         c = r;
      end
      return c ^ xorv;
   endfunction

   task automatic drive(input int which, input logic [15:0] d, input bit v,
                        input bit s, input bit e);
      if (which == 0) begin
         i0_d = d; i0_v = v; i0_s = s; i0_e = e;
      end else begin
         i1_d = d[7:0]; i1_v = v; i1_s = s; i1_e = e;
      end
   endtask

   task automatic send_frame(input int which, input int unsigned words[$],
                             input int max_hole, input int tail, input string tag);
      int w = (which == 0) ? 16 : 8;
      int nw = 16 / w;
      int n = words.size();
      logic [15:0] chk;
      if (which == 0) chk = ref_crc(words, 16, P0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000);
      else            chk = ref_crc(words, 8, P1, 16'hFFFF, 1'b1, 1'b1, 1'b1, X1);
      for (int k = 0; k < n; k++) begin
         q_data[which].push_back(words[k]);
         q_s[which].push_back(k == 0);
         q_e[which].push_back(1'b0);
         q_tag[which].push_back({"R1 ", tag});
      end
      for (int j = 0; j < nw; j++) begin
         q_data[which].push_back((chk >> (w * (nw - 1 - j))) & ((1 << w) - 1));
         q_s[which].push_back(1'b0);
         q_e[which].push_back(j == nw - 1);
         q_tag[which].push_back({"R2 ", tag});
      end
      for (int k = 0; k < n; k++) begin
         int holes = (max_hole > 0) ? $urandom_range(max_hole, 0) : 0;
         repeat (holes) begin
            @(negedge clk);
            // R3: junk on invalid cycles, including stray strobes
            drive(which, 16'($urandom), 1'b0, 1'($urandom), 1'($urandom));
         end
         @(negedge clk);
         drive(which, 16'(words[k]), 1'b1, k == 0, k == n - 1);
      end
      repeat (tail) begin
         @(negedge clk);
         drive(which, 16'($urandom), 1'b0, 1'b0, 1'b0);
      end
   endtask

   task automatic mon(input int which, input bit v, input bit s, input bit e,
                      input int unsigned d);
      if (v) begin
         if (q_data[which].size() == 0) begin
            check("R3", 1'b0, "unexpected output word", d, 0);
         end else begin
            int unsigned ed = q_data[which].pop_front();
            bit es = q_s[which].pop_front();
            bit ee = q_e[which].pop_front();
            string t = q_tag[which].pop_front();
            check(t, d == ed, "data", d, ed);
            check(t, s == es && e == ee, "start/end", {s, e}, {es, ee});
         end
      end else begin
         check("R3", d == 0 && !s && !e, "idle output", d, 0);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run) begin
         mon(0, o0_v, o0_s, o0_e, o0_d);
         mon(1, o1_v, o1_s, o1_e, o1_d);
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int unsigned m[$];
      void'($urandom(32'h0005EED1));
      repeat (4) @(negedge clk);
      // R11: outputs quiet during reset
      check("R11", !o0_v && !o0_s && !o0_e && o0_d == 0, "u0 reset outputs", o0_d, 0);
      check("R11", !o1_v && !o1_s && !o1_e && o1_d == 0, "u1 reset outputs", o1_d, 0);
      rst_n = 1'b1;
      run = 1'b1;

      // R4: single-word frames, start and end on one cycle
      m = '{32'h1234};
      send_frame(0, m, 0, 3, "R4 R5");
      m = '{32'h5A};
      send_frame(1, m, 0, 4, "R4 R6 R7 R8 R9 R10");
      // R5: all-ones and all-zero words
      m = '{32'hFFFF, 32'h0000, 32'hFFFF};
      send_frame(0, m, 0, 2, "R5");
      m = '{32'h31, 32'h32, 32'h33, 32'h34, 32'h35, 32'h36, 32'h37, 32'h38, 32'h39};
      send_frame(1, m, 0, 2, "R6 R8 R9 R10");
      // R12: back-to-back frames with the minimum gap
      for (int f = 0; f < 6; f++) begin
         m.delete();
         for (int k = 0; k < 1 + f % 3; k++) m.push_back($urandom_range(16'hFFFF, 0));
         send_frame(0, m, 0, 1, "R12");
      end
      for (int f = 0; f < 6; f++) begin
         m.delete();
         for (int k = 0; k < 1 + f % 4; k++) m.push_back($urandom_range(8'hFF, 0));
         send_frame(1, m, 0, 2, "R12 R7");
      end
      // R3: random frames with invalid holes carrying junk
      for (int f = 0; f < 40; f++) begin
         m.delete();
         for (int k = 0; k < $urandom_range(6, 1); k++) m.push_back($urandom_range(16'hFFFF, 0));
         send_frame(0, m, 3, 1 + $urandom_range(3, 0), "R3 R5");
      end
      for (int f = 0; f < 40; f++) begin
         m.delete();
         for (int k = 0; k < $urandom_range(8, 1); k++) m.push_back($urandom_range(8'hFF, 0));
         send_frame(1, m, 3, 2 + $urandom_range(3, 0), "R3 R6 R8 R9 R10");
      end
      repeat (6) @(negedge clk);
      // R2: every expected checksum word was delivered
      check("R2", q_data[0].size() == 0, "u0 words left", q_data[0].size(), 0);
      check("R2", q_data[1].size() == 0, "u1 words left", q_data[1].size(), 0);
      summary();
   end

endmodule